// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a parameterized boundary-scan register placed around a device core. Each primary input of the device gets an input cell sitting between the input pin and the core. Each primary output gets an output cell sitting between the core and the output pin. All cells are linked into one serial path that starts at `tdi` and ends at `tdo`. The scan path is independent of what the core does. When the block is not in test drive, it is transparent to the device's function.

Test control arrives as direct strobes in the test clock domain: `capture_en`, `shift_en` and `update_en`, plus a `test_mode` level. The strobes come already decoded from the test access port, so that port, its state machine and its instruction register are not part of this block. Every cell holds two stages:

- a shift stage, which is loaded either by capture or by serial shift;
- a separate update stage, which feeds the cell output while `test_mode` is high.

Because the stages are separate, the pins and the core inputs keep their values while new data moves through the chain. Several instances can be linked `tdo` to `tdi` on a board. Linked this way, they can drive a stimulus from one device's output pins and read it back through another device's input cells. This is an interconnect test.

Top module: `bsr_chain`

## Requirements
- R1: While `rst` is high (synchronous, active high), each output passes its functional input through. After a rising edge with `rst` high, every shift stage and every update stage holds 0.
- R2: With `test_mode` low, `core_in` equals `pin_in` and `pin_out` equals `core_out` in the same cycle, whatever the strobes do.
- R3: With `test_mode` high and `rst` low, `core_in[k]` is the update stage of input cell k and `pin_out[j]` is the update stage of output cell j. Changes on `pin_in` and `core_out` do not reach these outputs.
- R4: A rising edge with `capture_en` high loads input cell k's shift stage with `pin_in[k]` and output cell j's shift stage with `core_out[j]`, all at once.
- R5: The serial order from `tdi` is input cells 0 to N_IN-1, then output cells 0 to N_OUT-1. A rising edge with `shift_en` high and `capture_en` low moves every shift stage one place toward `tdo` and loads input cell 0 from `tdi`. `tdo` is always the shift stage of output cell N_OUT-1.
- R6: A rising edge with `update_en` high and the other two strobes low copies every shift stage into its update stage. In test mode, the new values appear on `pin_out` and `core_in` after that edge.
- R7: In test mode, `pin_out` and `core_in` hold their values across every edge that is not an update. This includes edges that capture or shift.
- R8: When several strobes are high on the same edge, capture wins over shift, and shift wins over update. The losing strobes have no effect.
- R9: Two instances linked `tdo` to `tdi`, with one instance's `pin_out` wired to the other's `pin_in`, form a serial path of 2*(N_IN+N_OUT) cells. In that path, a stimulus shifted and updated into the first instance's output cells is captured by the second instance's input cells and comes out at the board `tdo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high test reset |
| test_mode | input | 1 | High selects test drive from the update stages |
| capture_en | input | 1 | Parallel load of the shift stages |
| shift_en | input | 1 | Serial move of the shift stages toward `tdo` |
| update_en | input | 1 | Copy of the shift stages into the update stages |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, the last output cell's shift stage |
| pin_in | input | N_IN | Device input pins |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Values the core sends toward the pins |
| pin_out | output | N_OUT | Device output pins |

## Verification
Several rules are checked on every clock cycle: the pass-through in normal mode, the clearing after reset, the parallel load on capture, the one-place move on shift, the copy on update, the hold of the test-drive outputs across non-update edges, and capture winning over shift. Other behaviour can only be shown by the bench's scenarios. These are the full serial order across two linked instances, the stimulus travelling from one device's output pins into the other's input cells, and whether a losing update strobe really leaves the pins alone once the data is shifted out and compared bit by bit.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

    // Operation applied to every cell on a rising test-clock edge.
    typedef enum logic [1:0] {
        BSR_IDLE    = 2'd0,
        BSR_CAPTURE = 2'd1,
        BSR_SHIFT   = 2'd2,
        BSR_UPDATE  = 2'd3
    } bsr_op_e;

    // Control word broadcast to all cells.
    typedef struct packed {
        bsr_op_e op;
        logic    drive_test;
    } bsr_ctl_t;

    // Fixed strobe priority: capture, then shift, then update.
    function automatic bsr_op_e bsr_pick_op(input logic cap, input logic sh, input logic upd);
        bsr_op_e op;
        if (cap)       op = BSR_CAPTURE;
        else if (sh)   op = BSR_SHIFT;
        else if (upd)  op = BSR_UPDATE;
        else           op = BSR_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
`timescale 1ns/1ps
module bsr_ctrl
    import bsr_pkg::*;
(
    input  logic     rst,
    input  logic     test_mode,
    input  logic     capture_en,
    input  logic     shift_en,
    input  logic     update_en,
    output bsr_ctl_t ctl
);

    always_comb begin
        ctl.op         = bsr_pick_op(capture_en, shift_en, update_en);
        // Reset forces functional pass-through.
        ctl.drive_test = test_mode && !rst;
    end

endmodule

// File: rtl/bsr_cell.sv
`timescale 1ns/1ps
module bsr_cell
    import bsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bsr_ctl_t ctl,
    input  logic     func_in,
    input  logic     scan_in,
    output logic     scan_out,
    output logic     func_out
);

    logic shift_q;
    logic hold_q;

    // Shift stage: parallel capture of the functional value or serial move.
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= 1'b0;
        end else begin
            case (ctl.op)
                BSR_CAPTURE: shift_q <= func_in;
                BSR_SHIFT:   shift_q <= scan_in;
                default:     shift_q <= shift_q;
            endcase
        end
    end

    // Update stage: only written on an update operation.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (ctl.op == BSR_UPDATE) begin
            hold_q <= shift_q;
        end
    end

    assign scan_out = shift_q;
    assign func_out = ctl.drive_test ? hold_q : func_in;

endmodule

// File: rtl/bsr_chain.sv
`timescale 1ns/1ps
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_mode,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out
);

    localparam int TOT = N_IN + N_OUT;

    bsr_ctl_t       ctl;
    logic [TOT-1:0] cell_din;
    logic [TOT-1:0] cell_dout;
    logic [TOT-1:0] scan_q;

    bsr_ctrl u_ctrl (
        .rst        (rst),
        .test_mode  (test_mode),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .ctl        (ctl)
    );

    // Input cells occupy the low positions (nearest tdi), output cells the high ones.
    assign cell_din = {core_out, pin_in};

    for (genvar i = 0; i < TOT; i++) begin : g_cell
        logic sin;
        if (i == 0) begin : g_head
            assign sin = tdi;
        end else begin : g_link
            assign sin = scan_q[i-1];
        end

        bsr_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .func_in  (cell_din[i]),
            .scan_in  (sin),
            .scan_out (scan_q[i]),
            .func_out (cell_dout[i])
        );
    end

    assign core_in = cell_dout[N_IN-1:0];
    assign pin_out = cell_dout[TOT-1:N_IN];
    assign tdo     = scan_q[TOT-1];

endmodule

// File: rtl/bsr_chain_chk.sv
`timescale 1ns/1ps
module bsr_chain_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   test_mode,
    input logic                   capture_en,
    input logic                   shift_en,
    input logic                   update_en,
    input logic                   tdi,
    input logic                   tdo,
    input logic [N_IN-1:0]        pin_in,
    input logic [N_IN-1:0]        core_in,
    input logic [N_OUT-1:0]       core_out,
    input logic [N_OUT-1:0]       pin_out,
    input logic [N_IN+N_OUT-1:0]  scan_q
);

    localparam int TOT = N_IN + N_OUT;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (scan_q == '0) && (!test_mode || (pin_out == '0 && core_in == '0)));

    // R2
    normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (pin_out == core_out) && (core_in == pin_in));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> scan_q == $past({core_out, pin_in}));

    // R5
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !capture_en) |=>
            (scan_q == {$past(scan_q[TOT-2:0]), $past(tdi)}) && (tdo == $past(scan_q[TOT-2])));

    // R6
    update_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (update_en && !capture_en && !shift_en && test_mode) |=>
            (!test_mode || (pin_out == $past(scan_q[TOT-1:N_IN]) && core_in == $past(scan_q[N_IN-1:0]))));

    // R7
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode && (!update_en || capture_en || shift_en)) |=>
            (!test_mode || ($stable(pin_out) && $stable(core_in))));

    // R8
    capture_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_en && shift_en) |=> tdo == $past(core_out[N_OUT-1]));

endmodule

bind bsr_chain bsr_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .test_mode  (test_mode),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .tdi        (tdi),
    .tdo        (tdo),
    .pin_in     (pin_in),
    .core_in    (core_in),
    .core_out   (core_out),
    .pin_out    (pin_out),
    .scan_q     (scan_q)
);

// File: tb/bsr_chain_bench.sv
`timescale 1ns/1ps
module bsr_chain_bench;

    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int BT    = 2 * (N_IN + N_OUT);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, test_mode, capture_en, shift_en, update_en, tdi;
    logic [3:0] a_pin_in, a_core_out, b_core_out;
    logic [3:0] a_core_in, a_pin_out, b_core_in, b_pin_out;
    logic mid_tdo, tdo;

    // Board: bench tdi -> A -> B -> bench tdo; A pin_out drives B pin_in.
    bsr_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr_chain (
        .clk(clk), .rst(rst), .test_mode(test_mode),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .tdi(tdi), .tdo(mid_tdo),
        .pin_in(a_pin_in), .core_in(a_core_in),
        .core_out(a_core_out), .pin_out(a_pin_out)
    );

    bsr_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr_chain_b (
        .clk(clk), .rst(rst), .test_mode(test_mode),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .tdi(mid_tdo), .tdo(tdo),
        .pin_in(a_pin_out), .core_in(b_core_in),
        .core_out(b_core_out), .pin_out(b_pin_out)
    );

    // Reference model: mg = shift stages, mu = update stages, bit 0 nearest tdi.
    logic [BT-1:0] mg, mu;
    logic exp_q[$];
    int checks = 0;
    int errors = 0;

    function automatic logic drv();
        return test_mode && !rst;
    endfunction
    function automatic logic [3:0] e_a_pin_out();
        return drv() ? mu[7:4] : a_core_out;
    endfunction
    function automatic logic [3:0] e_a_core_in();
        return drv() ? mu[3:0] : a_pin_in;
    endfunction
    function automatic logic [3:0] e_b_core_in();
        return drv() ? mu[11:8] : e_a_pin_out();
    endfunction
    function automatic logic [3:0] e_b_pin_out();
        return drv() ? mu[15:12] : b_core_out;
    endfunction

    task automatic check4(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check4(req, "A pin_out", a_pin_out, e_a_pin_out());
        check4(req, "A core_in", a_core_in, e_a_core_in());
        check4(req, "B core_in", b_core_in, e_b_core_in());
        check4(req, "B pin_out", b_pin_out, e_b_pin_out());
    endtask

    // One test-clock cycle; the model applies the priority rule (R8).
    task automatic step(input logic c, input logic s, input logic u, input logic t);
        logic [BT-1:0] cap_val;
        capture_en = c; shift_en = s; update_en = u; tdi = t;
        if (s && !c && !rst) exp_q.push_back(mg[BT-1]);
        cap_val = {b_core_out, e_a_pin_out(), a_core_out, a_pin_in};
        @(posedge clk);
        if (rst) begin
            mg = '0; mu = '0;
        end else if (c) begin
            mg = cap_val;
        end else if (s) begin
            mg = {mg[BT-2:0], t};
        end else if (u) begin
            mu = mg;
        end
        #1;
        capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
    endtask

    task automatic shift_word(input logic [BT-1:0] d);
        for (int k = 0; k < BT; k++) step(1'b0, 1'b1, 1'b0, d[BT-1-k]);
    endtask

    // Scoreboard monitor: compares serial output before each shifting edge (R5, R9).
    always @(negedge clk) begin
        if (shift_en && !capture_en && !rst) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 tdo: actual %b expected <none queued>", tdo);
            end else begin
                automatic logic e = exp_q.pop_front();
                if (tdo !== e) begin
                    errors++;
                    $display("FAIL R9 tdo: actual %b expected %b", tdo, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [BT-1:0] pats [5];

    initial begin
        rst = 1'b1; test_mode = 1'b1;
        capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0; tdi = 1'b0;
        a_pin_in = 4'h3; a_core_out = 4'hC; b_core_out = 4'h6;
        mg = '0; mu = '0;
        pats[0] = 16'h9A35; pats[1] = 16'h4C5E; pats[2] = 16'hE0F1;
        pats[3] = 16'h7707; pats[4] = 16'h1B92;

        // R1: reset forces pass-through even with test_mode high
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0);
            check_outputs("R1");
        end
        rst = 1'b0;
        #1;
        check_outputs("R1"); // cleared update stages now drive

        // R4 R5 R6 R9: interconnect test, several stimulus patterns
        for (int p = 0; p < 5; p++) begin
            shift_word(pats[p]);      // reads out the previous capture
            step(1'b0, 1'b0, 1'b1, 1'b0);
            check_outputs("R6");
            check4("R9", "A pin_out stimulus", a_pin_out, pats[p][7:4]);
            a_pin_in   = a_pin_in + 4'h5;
            a_core_out = ~a_core_out;
            b_core_out = b_core_out ^ 4'h9;
            #1;
            check_outputs("R3");
            step(1'b1, 1'b0, 1'b0, 1'b0);
            check_outputs("R7");
        end

        // R8: capture beats shift, shift beats update
        a_pin_in = 4'hA; a_core_out = 4'h5; b_core_out = 4'hD;
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check_outputs("R8");
        step(1'b0, 1'b1, 1'b1, 1'b1);
        check_outputs("R8");
        shift_word(16'h0F3C);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check_outputs("R6");

        // R2: normal mode pass-through
        test_mode = 1'b0;
        for (int k = 0; k < 4; k++) begin
            a_pin_in   = 4'(k * 3 + 1);
            a_core_out = 4'(k * 5 + 2);
            b_core_out = 4'(15 - k);
            #1;
            check_outputs("R2");
        end
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check_outputs("R2");
        test_mode = 1'b1;
        #1;
        check_outputs("R3");

        shift_word('0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 queue: actual %0d pending expected 0", exp_q.size());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule